// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block merges sixteen level-sensitive external interrupt lines with a software-interrupt register. It then decides whether a processor core should take an external-interrupt trap and at which level. The merged vector is compared against the core's current priority level. The highest pending level above that priority is encoded as a trap type, which is the external-interrupt trap base ORed with the level number. That trap type is presented to the core together with a request flag.

A new request is raised only when the encoded trap type changes. It is held back while the core is already inside a trap of a higher type. It is withdrawn when no level beats the priority or when interrupts are globally disabled. A separate one-cycle wake pulse reports each rising external line so that a halted core can resume. All outputs are registered and follow their inputs one clock later.

Top module: `pil_arbiter`

## Requirements
- R1: The pending vector is the OR of the external lines and the software-interrupt register bits 15..1. Software bits 0 and 16 are timer-match bits and do not map directly onto levels 0 and 16.
- R2: If software bit 0 or software bit 16 is set, level 14 is pending.
- R3: When the pending vector, taken as an unsigned number, is below 2 shifted left by the current priority level, any outstanding request is dropped and the trap type output is cleared to zero.
- R4: With interrupts enabled and a level above the priority pending, the highest pending level L wins, and the trap type becomes 0x040 OR L.
- R5: When the trap level is nonzero and the in-service trap type is greater than the candidate trap type, the request and trap type outputs keep their previous values.
- R6: With interrupts disabled, an outstanding request is dropped and the trap type is cleared to zero.
- R7: The wake output is high for the one cycle after any external line goes from low to high. A falling line or a line held high does not pulse it.
- R8: Reset clears the request flag, the trap type and the wake output.
- R9: The request, trap type and wake outputs change on the first clock edge after the input change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 16 | Level-sensitive external interrupt lines, bit n = level n |
| softint | input | 17 | Software-interrupt register; bits 0 and 16 are timer-match bits |
| cur_pri | input | 4 | Current processor interrupt priority level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| svc_tt | input | 9 | Trap type currently in service |
| irq_req | output | 1 | Hard-interrupt request to the core |
| irq_tt | output | 9 | Encoded external-interrupt trap type |
| wake | output | 1 | One-cycle pulse on any rising external line |

## Verification
Single external lines at every level show whether the encoding and the priority threshold are right. Overlapping lines and software bits show whether the scan really picks the highest level. The timer-match bits are driven alone, so a fold onto level 14 cannot be confused with a direct mapping of bit 0. Priority set at, just below and above the winning level separates a strict from a non-strict comparison. Toggling the enable and the trap-level gate while a request is outstanding distinguishes holding, withdrawing and re-raising. Sparse random lines, random software bits and random priorities then mix all of these.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;
    localparam int TT_W = 9;
    typedef logic [TT_W-1:0] trap_type_t;

    function automatic trap_type_t make_code(input trap_type_t base, input logic [3:0] lvl);
        return base | trap_type_t'(lvl);
    endfunction
endpackage

// File: rtl/pil_pending_merge.sv
module pil_pending_merge #(
    parameter int NUM_LEVELS = 16,
    parameter int FOLD_LEVEL = 14
) (
    input  logic [NUM_LEVELS-1:0] ext_lines,
    input  logic [NUM_LEVELS:0]   soft_bits,
    output logic [NUM_LEVELS-1:0] pend_vec
);
    logic timer_hit;
    logic [NUM_LEVELS-1:0] soft_direct;

    always_comb begin
        timer_hit   = soft_bits[0] | soft_bits[NUM_LEVELS];
        soft_direct = {soft_bits[NUM_LEVELS-1:1], 1'b0};
        pend_vec    = ext_lines | soft_direct;
        if (timer_hit) pend_vec[FOLD_LEVEL] = 1'b1;
    end
endmodule

// File: rtl/pil_priority_pick.sv
module pil_priority_pick #(
    parameter int NUM_LEVELS = 16,
    localparam int PRI_W = $clog2(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-1:0] pend_vec,
    input  logic [PRI_W-1:0]      pri,
    output logic                  below_pri,
    output logic                  found,
    output logic [PRI_W-1:0]      level
);
    localparam int CMP_W = NUM_LEVELS + 1;
    logic [CMP_W-1:0] threshold;

    always_comb begin
        threshold = CMP_W'(2) << pri;
        below_pri = {1'b0, pend_vec} < threshold;
        found     = 1'b0;
        level     = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (pend_vec[i] && (i > int'(pri))) begin
                found = 1'b1;
                level = PRI_W'(i);
            end
        end
    end
endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter
    import pil_arb_pkg::*;
#(
    parameter int         NUM_LEVELS = 16,
    parameter int         FOLD_LEVEL = 14,
    parameter int         TL_W       = 3,
    parameter trap_type_t EXT_BASE   = 9'h040
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LEVELS-1:0]           irq_lines,
    input  logic [NUM_LEVELS:0]             softint,
    input  logic [$clog2(NUM_LEVELS)-1:0]   cur_pri,
    input  logic                            int_en,
    input  logic [TL_W-1:0]                 trap_lvl,
    input  logic [TT_W-1:0]                 svc_tt,
    output logic                            irq_req,
    output logic [TT_W-1:0]                 irq_tt,
    output logic                            wake
);
    localparam int PRI_W = $clog2(NUM_LEVELS);

    typedef struct packed {
        logic                  req;
        trap_type_t            tt;
        logic                  wake;
        logic [NUM_LEVELS-1:0] prev;
    } arb_state_t;

    arb_state_t state_d, state_q;
    logic [NUM_LEVELS-1:0] pend_vec;
    logic                  below_pri, found;
    logic [PRI_W-1:0]      win_level;
    trap_type_t            cand_tt;

    pil_pending_merge #(.NUM_LEVELS(NUM_LEVELS), .FOLD_LEVEL(FOLD_LEVEL)) u_merge (
        .ext_lines(irq_lines), .soft_bits(softint), .pend_vec(pend_vec)
    );

    pil_priority_pick #(.NUM_LEVELS(NUM_LEVELS)) u_pick (
        .pend_vec(pend_vec), .pri(cur_pri),
        .below_pri(below_pri), .found(found), .level(win_level)
    );

    always_comb begin
        state_d      = state_q;
        state_d.wake = |(irq_lines & ~state_q.prev);
        state_d.prev = irq_lines;
        cand_tt      = make_code(EXT_BASE, 4'(win_level));
        if (below_pri) begin
            if (state_q.req) begin
                state_d.req = 1'b0;
                state_d.tt  = '0;
            end
        end else if (int_en) begin
            if (found && !((trap_lvl != '0) && (svc_tt > cand_tt))
                      && (state_q.tt != cand_tt)) begin
                state_d.req = 1'b1;
                state_d.tt  = cand_tt;
            end
        end else if (state_q.req) begin
            state_d.req = 1'b0;
            state_d.tt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_req = state_q.req;
    assign irq_tt  = state_q.tt;
    assign wake    = state_q.wake;

    // R4
    req_code_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_tt[TT_W-1:4] == EXT_BASE[TT_W-1:4]));

    // R3
    below_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (below_pri && irq_req) |=> (!irq_req && irq_tt == '0));

    // R6
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && irq_req) |=> !irq_req);

    // R5
    tl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && trap_lvl != '0 && svc_tt > (EXT_BASE | trap_type_t'(NUM_LEVELS-1)))
        |=> !irq_req);

    // R7
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(irq_lines) != '0));

    // R4
    raise_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_tt != '0));
endmodule

// File: tb/sim_pil_arbiter.sv
module sim_pil_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic [16:0] softint = '0;
    logic [3:0]  cur_pri = '0;
    logic        int_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  svc_tt = '0;
    logic        irq_req, wake;
    logic [8:0]  irq_tt;

    int n_checks = 0, n_fail = 0;
    logic        m_req = 0, m_wake = 0;
    logic [8:0]  m_tt = 0;
    logic [15:0] m_prev = 0;

    always #10 clk = ~clk;

    pil_arbiter u0 (.clk, .rst_n, .irq_lines, .softint, .cur_pri, .int_en,
                    .trap_lvl, .svc_tt, .irq_req, .irq_tt, .wake);

    initial begin
        #3_000_000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    function automatic logic [15:0] pend_of(input logic [15:0] l, input logic [16:0] s);
        logic [15:0] p = l | {s[15:1], 1'b0};
        if (s[0] | s[16]) p[14] = 1'b1;
        return p;
    endfunction

    task automatic model_step();
        logic [15:0] p = pend_of(irq_lines, softint);
        logic [8:0]  code = 0;
        m_wake = |(irq_lines & ~m_prev);
        m_prev = irq_lines;
        if ({1'b0, p} < (17'd2 << cur_pri)) begin
            if (m_req) begin m_req = 0; m_tt = 0; end
        end else if (int_en) begin
            for (int i = 0; i < 16; i++) if (p[i]) code = 9'h040 | 9'(i);
            if (!(trap_lvl != 0 && svc_tt > code) && m_tt != code) begin
                m_req = 1; m_tt = code;
            end
        end else if (m_req) begin
            m_req = 0; m_tt = 0;
        end
    endtask

    task automatic check(input string tag);
        n_checks++;
        if (irq_req !== m_req || irq_tt !== m_tt || wake !== m_wake) begin
            n_fail++;
            $display("FAIL %s: actual req=%0b tt=%h wake=%0b expected req=%0b tt=%h wake=%0b",
                     tag, irq_req, irq_tt, wake, m_req, m_tt, m_wake);
        end
    endtask

    task automatic step(input logic [15:0] l, input logic [16:0] s, input logic [3:0] p,
                        input logic en, input logic [2:0] tl, input logic [8:0] tt,
                        input string tag);
        @(negedge clk);
        irq_lines = l; softint = s; cur_pri = p; int_en = en; trap_lvl = tl; svc_tt = tt;
        model_step();
        @(posedge clk); #2;
        check(tag);
    endtask

    initial begin
        #35; check("R8 reset");
        @(negedge clk); rst_n = 1;
        step(16'h0020, 0, 0, 1, 0, 0, "R4 R9 line5 R7 wake");
        if (irq_tt !== 9'h045) begin n_checks++; n_fail++;
            $display("FAIL R4: actual tt=%h expected 045", irq_tt); end else n_checks++;
        step(16'h1020, 0, 0, 1, 0, 0, "R4 highest of 5,12");
        step(16'h1020, 0, 0, 1, 0, 0, "R7 held line no wake");
        step(16'h0020, 0, 12, 1, 0, 0, "R3 below priority");
        step(16'h0020, 0, 5, 1, 0, 0, "R3 equal priority not above");
        step(16'h0020, 0, 4, 1, 0, 0, "R3 one below raises");
        step(16'h0000, 17'h00001, 0, 1, 0, 0, "R2 tick fold to 14, R7 fall no wake");
        step(0, 17'h10000, 0, 1, 0, 0, "R2 stick fold to 14");
        step(0, 17'h00008, 0, 1, 0, 0, "R1 soft bit 3");
        step(0, 17'h00008, 0, 0, 0, 0, "R6 disable drops");
        step(16'h0008, 0, 0, 1, 1, 9'h04F, "R5 tl suppress");
        step(16'h0008, 0, 0, 1, 0, 9'h04F, "R5 tl zero raises");
        step(16'h8008, 0, 0, 1, 2, 9'h04E, "R5 higher candidate passes");
        step(16'hFFFF, 17'h1FFFF, 15, 1, 0, 0, "R3 priority 15");
        step(16'h0001, 0, 0, 1, 0, 0, "R1 level0 never above");
        begin
            void'($urandom(32'd1234));
            for (int k = 0; k < 400; k++) begin
                logic [15:0] l = 16'($urandom) & 16'($urandom) & 16'($urandom);
                logic [16:0] s = 17'($urandom) & 17'($urandom) & 17'($urandom) & 17'($urandom);
                step(l, s, 4'($urandom % 16), ($urandom % 8) != 0, 3'($urandom % 3),
                     9'h040 | 9'($urandom % 16), "R4 R1 R2 random");
            end
        end
        @(negedge clk); rst_n = 0; m_req = 0; m_tt = 0; m_wake = 0; m_prev = 0;
        #2; check("R8 async reset");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule